// File: doc/BRIEF.md
# Inner Product Step Cell

This block is one pipelined processing element for a linear systolic array. On every clock it takes a signed operand pair A and B and a signed addend C. One cycle later it presents three results together: A and B forwarded unchanged, and the multiply-accumulate value A*B + C. Because the forwarded operands take exactly as long as the sum, identical cells can be chained. Each cell hands its operands to its neighbour with the same timing as its partial result.

The outputs have no meaning until a sample has passed through the register stage. A valid flag therefore travels alongside the data: a qualifier on the inputs is registered once and marks the outputs of the following cycle. The result is either kept at full precision (2*W+1 bits, so it cannot overflow) or, under a parameter, reduced modulo 2^W to the operand width.

Top module: `ips_cell`

## Requirements
- R1: In the first cycle after a synchronous reset (rst high at a rising edge), out_valid is 0 and a_out, b_out and c_out are all zero.
- R2: a_out equals the a_in value sampled at the previous rising edge.
- R3: b_out equals the b_in value sampled at the previous rising edge.
- R4: With WRAP_RESULT = 0, c_out is 2*DATA_W+1 bits wide and equals the exact signed value a_in*b_in + c_in from the previous edge.
- R5: With WRAP_RESULT = 1, c_out is DATA_W bits wide and equals the low DATA_W bits of a_in*b_in + c_in from the previous edge, read as two's complement.
- R6: out_valid equals in_valid from the previous edge. In the cycle after any reset edge it is 0.
- R7: All three data outputs change on the same edge and always belong to the same input sample.
- R8: Operands and addend are two's complement. The most negative and most positive operand values give the exact mathematical result in full-precision mode.
- R9: A reset asserted in the middle of a stream clears out_valid and the data outputs at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the current input sample as meaningful |
| a_in | input | DATA_W | Signed operand A |
| b_in | input | DATA_W | Signed operand B |
| c_in | input | DATA_W | Signed addend C |
| out_valid | output | 1 | Marks the outputs as meaningful |
| a_out | output | DATA_W | A forwarded after one cycle |
| b_out | output | DATA_W | B forwarded after one cycle |
| c_out | output | 2*DATA_W+1 or DATA_W | A*B + C after one cycle |

## Verification
The bench drives the short ascending operand stream that should give 10, 17 and 26. A cell that skews one lane by a cycle pairs a product with the wrong addend, and the mismatch shows up there. Operand extremes catch a design that multiplies unsigned values or sign-extends the addend badly: it returns a large positive value where a negative one is due. A second instance in wrap mode checks the modulo behaviour, and a reset applied mid-stream exposes a valid flag that lingers for one cycle.

// File: rtl/ips_pkg.sv
package ips_pkg;

   // Width of the accumulated result for a given operand width and mode.
   function automatic int res_w(input int data_w, input bit wrap);
      return wrap ? data_w : 2 * data_w + 1;
   endfunction

   // Width of the raw product before the addend is applied.
   function automatic int prod_w(input int data_w);
      return 2 * data_w;
   endfunction

endpackage

// File: rtl/ips_pipe_reg.sv
module ips_pipe_reg #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] d,
   output logic signed [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("ips_pipe_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R2 R3
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> q == $past(d));

endmodule

// File: rtl/ips_valid_track.sv
module ips_valid_track (
   input  logic clk,
   input  logic rst,
   input  logic vin,
   output logic vout
);

   always_ff @(posedge clk) begin
      if (rst) vout <= 1'b0;
      else     vout <= vin;
   end

   // R6
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> vout == $past(vin));

   // R1 R9
   valid_reset_chk: assert property (@(posedge clk)
      $past(rst) |-> !vout);

endmodule

// File: rtl/ips_mac_stage.sv
module ips_mac_stage
   import ips_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit WRAP_RESULT = 1'b0,
   localparam int RW = res_w(DATA_W, WRAP_RESULT),
   localparam int PW = prod_w(DATA_W),
   localparam int FW = 2 * DATA_W + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] a,
   input  logic signed [DATA_W-1:0] b,
   input  logic signed [DATA_W-1:0] c,
   output logic signed [RW-1:0]     acc
);

   if (DATA_W < 2) begin : g_bad_w
      $error("ips_mac_stage: DATA_W must be at least 2");
   end

   logic signed [PW-1:0] prod;
   logic signed [FW-1:0] prod_x;
   logic signed [FW-1:0] add_x;
   logic signed [FW-1:0] sum_full;
   logic signed [RW-1:0] sum_sel;

   always_comb begin
      prod     = a * b;
      prod_x   = {prod[PW-1], prod};
      add_x    = {{(FW-DATA_W){c[DATA_W-1]}}, c};
      sum_full = prod_x + add_x;
   end

   if (WRAP_RESULT) begin : g_wrap
      assign sum_sel = sum_full[DATA_W-1:0];
   end else begin : g_full
      assign sum_sel = sum_full;
   end

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= sum_sel;
   end

   // R4 R5
   mac_result_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> acc == RW'($past(a) * $past(b) + $past(c)));

   // R1 R9
   mac_reset_chk: assert property (@(posedge clk)
      $past(rst) |-> acc == '0);

endmodule

// File: rtl/ips_cell.sv
module ips_cell
   import ips_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit WRAP_RESULT = 1'b0
) (
   input  logic                                            clk,
   input  logic                                            rst,
   input  logic                                            in_valid,
   input  logic signed [DATA_W-1:0]                        a_in,
   input  logic signed [DATA_W-1:0]                        b_in,
   input  logic signed [DATA_W-1:0]                        c_in,
   output logic                                            out_valid,
   output logic signed [DATA_W-1:0]                        a_out,
   output logic signed [DATA_W-1:0]                        b_out,
   output logic signed [res_w(DATA_W, WRAP_RESULT)-1:0]    c_out
);

   if (DATA_W < 2 || DATA_W > 31) begin : g_bad_w
      $error("ips_cell: DATA_W must lie in 2..31");
   end

   ips_pipe_reg #(.W(DATA_W)) u_a_lane (
      .clk(clk), .rst(rst), .d(a_in), .q(a_out));

   ips_pipe_reg #(.W(DATA_W)) u_b_lane (
      .clk(clk), .rst(rst), .d(b_in), .q(b_out));

   ips_mac_stage #(.DATA_W(DATA_W), .WRAP_RESULT(WRAP_RESULT)) u_mac (
      .clk(clk), .rst(rst), .a(a_in), .b(b_in), .c(c_in), .acc(c_out));

   ips_valid_track u_valid (
      .clk(clk), .rst(rst), .vin(in_valid), .vout(out_valid));

   // R7
   lanes_coherent_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(a_out) || !$stable(b_out)) && !$past(rst) |->
         c_out == $bits(c_out)'($past(a_in) * $past(b_in) + $past(c_in)));

endmodule

// File: tb/tb_ips_cell.sv
module tb_ips_cell;

   localparam int W  = 16;
   localparam int WW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic                   vin;
   logic signed [W-1:0]    a, b, c;
   logic                   vout;
   logic signed [W-1:0]    ao, bo;
   logic signed [2*W:0]    co;

   logic signed [WW-1:0]   wa, wb, wc;
   logic                   wvout;
   logic signed [WW-1:0]   wao, wbo, wco;

   int checks = 0;
   int errors = 0;

   ips_cell #(.DATA_W(W), .WRAP_RESULT(1'b0)) dut (
      .clk(clk), .rst(rst), .in_valid(vin), .a_in(a), .b_in(b), .c_in(c),
      .out_valid(vout), .a_out(ao), .b_out(bo), .c_out(co));

   ips_cell #(.DATA_W(WW), .WRAP_RESULT(1'b1)) dut_wrap (
      .clk(clk), .rst(rst), .in_valid(vin), .a_in(wa), .b_in(wb), .c_in(wc),
      .out_valid(wvout), .a_out(wao), .b_out(wbo), .c_out(wco));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Apply inputs, pass one rising edge, then settle past it.
   task automatic step(input logic v, input int ai, input int bi, input int ci);
      vin = v; a = W'(ai); b = W'(bi); c = W'(ci);
      @(posedge clk); #1;
   endtask

   task automatic check_all(input string req, input logic v,
                            input longint ea, input longint eb, input longint ec);
      chk({req, " valid"}, longint'(vout), longint'(v));
      chk({req, " a_out"}, longint'(ao), ea);
      chk({req, " b_out"}, longint'(bo), eb);
      chk({req, " c_out"}, longint'(co), ec);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(1'b1, 9, 9, 9);
      // R1: outputs zero and invalid after the reset edge
      check_all("R1", 1'b0, 0, 0, 0);
      rst = 1'b0;
   endtask

   task automatic t_vector();
      // R2 R3 R4 R7: stream 1,2,3 / 4,5,6 / 6,7,8
      step(1'b1, 1, 4, 6);  check_all("R2 R3 R4 R7", 1'b1, 1, 4, 10);
      step(1'b1, 2, 5, 7);  check_all("R2 R3 R4 R7", 1'b1, 2, 5, 17);
      step(1'b1, 3, 6, 8);  check_all("R2 R3 R4 R7", 1'b1, 3, 6, 26);
      step(1'b1, -7, 9, -3); check_all("R4 signed", 1'b1, -7, 9, -66);
   endtask

   task automatic t_extremes();
      // R8: most negative and most positive operands
      step(1'b1, -32768, -32768, 32767);
      check_all("R8 min*min+max", 1'b1, -32768, -32768, 1073774591);
      step(1'b1, -32768, 32767, -32768);
      check_all("R8 min*max+min", 1'b1, -32768, 32767, -1073741824);
      step(1'b1, 32767, 32767, 32767);
      check_all("R8 max*max+max", 1'b1, 32767, 32767, 1073709056);
   endtask

   task automatic t_valid();
      // R6: valid follows in_valid by one cycle
      step(1'b0, 5, 5, 5);  chk("R6 low",  longint'(vout), 0);
      step(1'b1, 2, 3, 1);  chk("R6 high", longint'(vout), 1);
      chk("R6 data", longint'(co), 7);
      step(1'b0, 0, 0, 0);  chk("R6 drop", longint'(vout), 0);
   endtask

   task automatic t_midreset();
      step(1'b1, 11, 12, 13);
      chk("R9 pre", longint'(vout), 1);
      rst = 1'b1;
      step(1'b1, 20, 21, 22);
      // R9: reset wins over live inputs
      check_all("R9", 1'b0, 0, 0, 0);
      rst = 1'b0;
      step(1'b1, 1, 1, 1);
      check_all("R9 resume", 1'b1, 1, 1, 2);
   endtask

   task automatic t_wrap();
      // R5: 100*3+10 = 310 -> 54 mod 256
      wa = 8'sd100; wb = 8'sd3; wc = 8'sd10;
      step(1'b1, 0, 0, 0);
      chk("R5 wrap pos", longint'(wco), 54);
      chk("R5 a lane", longint'(wao), 100);
      // R5: -128*-1+0 = 128 -> -128
      wa = -8'sd128; wb = -8'sd1; wc = 8'sd0;
      step(1'b1, 0, 0, 0);
      chk("R5 wrap neg", longint'(wco), -128);
      chk("R5 b lane", longint'(wbo), -1);
      chk("R5 valid", longint'(wvout), 1);
   endtask

   initial begin
      vin = 1'b0; a = '0; b = '0; c = '0;
      wa = '0; wb = '0; wc = '0;
      t_reset();
      t_vector();
      t_extremes();
      t_valid();
      t_midreset();
      t_wrap();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule